// File: doc/BRIEF.md
# Write-Only I2C Register Target

This block is an I2C target that only accepts write transfers. It runs on a fast system clock and oversamples the bus lines, which are asynchronous to that clock. It drives the data line low through an open-drain enable output; the pad logic outside the block does the driving. Its 7-bit bus address is a fixed upper part plus two low bits that are set by a strap input.

A transfer begins with START and then the address byte. When the address matches and the direction bit requests a write, the first byte after the address loads an 8-bit register pointer. Every byte after that is a data byte. Each data byte leaves the block on a one-cycle write strobe, together with the pointer value and the byte. The pointer then steps by one, so a burst fills consecutive registers. The register file sits outside the block.

The system clock must run at least 16 times faster than SCL. The bus clock may run at up to 400 kHz.

Top module: `i2c_wr_target`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal binary 11000 followed by `strap[1]` and `strap[0]`. The byte arrives MSB first, so for strap 00 the matching byte is 0xC0, and for strap 10 it is 0xC4.
- R2: The direction bit is bit 0 of the address byte. An address byte with bit 0 set to 1 is never acknowledged.
- R3: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A repeated START in the middle of a transfer makes the next byte an address byte again, and a STOP releases SDA.
- R4: A data bit is taken while SCL is high, and each byte arrives most significant bit first.
- R5: After an accepted address byte, after the pointer byte and after each data byte, `sda_oe` is 1 throughout the high phase of the ninth SCL pulse.
- R6: The first byte after an accepted address loads the register pointer and produces no write strobe.
- R7: Each data byte produces exactly one `reg_we` pulse, one system clock long. In that same cycle, `reg_addr` holds the current pointer and `reg_wdata` holds the byte. The pointer then advances by one.
- R8: The pointer is 8 bits wide and wraps from 0xFF to 0x00 during a burst.
- R9: After an address mismatch or a read request, the block keeps SDA released and writes nothing until the next START or STOP.
- R10: While `rst_n` is low, `sda_oe` and `reg_we` are 0 and `reg_addr` and `reg_wdata` are 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen at the pad, asynchronous |
| strap | input | 2 | Low two bits of the bus address |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_addr | output | 8 | Register address for the write |
| reg_wdata | output | 8 | Data byte for the write |

## Verification
A wrong byte count or a wrong byte type would show up in the first acknowledge slot or the first write strobe after it. The symptom is a missing or misplaced `sda_oe`, or a strobe that carries the pointer byte as data. A fault in the pointer shows up as a wrong `reg_addr` on the second strobe of a burst, or at the 0xFF to 0x00 wrap. If the block fails to return to address reception, the first repeated START exposes it, because the next write lands at the wrong address or is never acknowledged. All of these faults show within one byte time, about nine SCL periods, of the event that caused them.

// File: rtl/i2cw_pkg.sv
// Shared types for the write-only I2C target.
// Assumes an 8-bit byte on the bus.
package i2cw_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {ST_IDLE, ST_RECV, ST_ACK, ST_SKIP} eng_st_t;
    typedef enum logic [1:0] {K_ADDR, K_PTR, K_DATA} byte_kind_t;

    // Bus events derived from the synchronized lines
    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic scl;
        logic sda;
    } bus_ev_t;
endpackage

// File: rtl/i2cw_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous single-bit lines.
// Assumes each line idles high (I2C pull-up), so it resets to 1.
module i2cw_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] d,
    output logic [LINES-1:0] q
);
    generate
        for (genvar i = 0; i < LINES; i++) begin : g_line
            logic [STAGES-1:0] pipe;
            // Shift the raw line through the synchronizer stages
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= '1;
                else        pipe <= {pipe[STAGES-2:0], d[i]};
            end
            assign q[i] = pipe[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/i2cw_events.sv
// Finds SCL edges and START/STOP conditions on synchronized bus samples.
// Assumes both inputs are already synchronous to clk.
module i2cw_events
    import i2cw_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_s,
    input  logic    sda_s,
    output bus_ev_t ev
);
    logic scl_q, sda_q;

    // Keep the previous sample of each line for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Decode edges and bus conditions
    always_comb begin
        ev.rise  = scl_s & ~scl_q;
        ev.fall  = ~scl_s & scl_q;
        ev.start = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop  = scl_s & scl_q & ~sda_q & sda_s;
        ev.scl   = scl_s;
        ev.sda   = sda_s;
    end
endmodule

// File: rtl/i2cw_engine.sv
// Byte engine: shifts bits in and decides each acknowledge. It loads the
// register pointer and issues one write strobe per data byte.
// Assumes that events arrive one per cycle at most and that clk runs >= 16x SCL.
module i2cw_engine
    import i2cw_pkg::*;
#(
    parameter int ADDR_W  = 7,
    parameter int STRAP_W = 2,
    parameter logic [ADDR_W-STRAP_W-1:0] ADDR_HI = 5'b11000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  bus_ev_t            ev,
    input  logic [STRAP_W-1:0] strap,
    output logic               sda_oe,
    output logic               reg_we,
    output logic [BYTE_W-1:0]  reg_addr,
    output logic [BYTE_W-1:0]  reg_wdata
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

    eng_st_t           st;
    byte_kind_t        kind;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] ptr;
    logic              addr_ok;

    // The address matches and the direction bit requests a write
    assign addr_ok = (shreg[BYTE_W-1 -: ADDR_W] == {ADDR_HI, strap}) && !shreg[0];

    // Main sequencer: bit capture, acknowledge and register write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            kind      <= K_ADDR;
            cnt       <= '0;
            shreg     <= '0;
            ptr       <= '0;
            sda_oe    <= 1'b0;
            reg_we    <= 1'b0;
            reg_addr  <= '0;
            reg_wdata <= '0;
        end else begin
            reg_we <= 1'b0;
            if (ev.stop) begin
                st     <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (ev.start) begin
                st     <= ST_RECV;
                kind   <= K_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else begin
                case (st)
                    ST_RECV: begin
                        if (ev.rise && cnt != LAST) begin
                            shreg <= {shreg[BYTE_W-2:0], ev.sda};
                            cnt   <= cnt + 1'b1;
                        end else if (ev.fall && cnt == LAST) begin
                            if (kind != K_ADDR || addr_ok) begin
                                sda_oe <= 1'b1;
                                st     <= ST_ACK;
                            end else begin
                                st <= ST_SKIP;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (ev.fall) begin
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                            st     <= ST_RECV;
                            case (kind)
                                K_ADDR: kind <= K_PTR;
                                K_PTR: begin
                                    ptr  <= shreg;
                                    kind <= K_DATA;
                                end
                                default: begin
                                    reg_we    <= 1'b1;
                                    reg_addr  <= ptr;
                                    reg_wdata <= shreg;
                                    ptr       <= ptr + 1'b1;
                                end
                            endcase
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // A write strobe lasts one cycle only
    assert_we_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // The pointer has advanced past the address just written, wrapping at the top
    assert_ptr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (ptr == BYTE_W'(reg_addr + 1'b1)));

    // A STOP always leaves SDA released
    assert_stop_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ev.stop |=> !sda_oe);

    // The acknowledge starts while SCL is low, never inside a high phase
    assert_ack_scl_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !ev.scl);
endmodule

// File: rtl/i2c_wr_target.sv
// Top of the write-only I2C target: synchronizers, event decoder and byte engine.
// Assumes SDA is driven open-drain outside the block, with sda_oe=1 pulling it low.
module i2c_wr_target
    import i2cw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] strap,
    output logic       sda_oe,
    output logic       reg_we,
    output logic [7:0] reg_addr,
    output logic [7:0] reg_wdata
);
    logic [1:0] lines_s;
    bus_ev_t    ev;

    i2cw_sync #(.LINES(2), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_i, sda_i}),
        .q     (lines_s)
    );

    i2cw_events u_events (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_s (lines_s[1]),
        .sda_s (lines_s[0]),
        .ev    (ev)
    );

    i2cw_engine #(.ADDR_W(7), .STRAP_W(2), .ADDR_HI(5'b11000)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (ev),
        .strap     (strap),
        .sda_oe    (sda_oe),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata)
    );
endmodule

// File: tb/i2c_wr_target_test.sv
module i2c_wr_target_test;
    localparam int Q = 10;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] strap = 2'b00;
    logic       sda_oe, reg_we;
    logic [7:0] reg_addr, reg_wdata;
    logic       sda_bus;

    assign sda_bus = sda_m & ~sda_oe;

    i2c_wr_target uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .strap(strap),
        .sda_oe(sda_oe), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
    );

    int checks = 0;
    int errors = 0;
    int wcount = 0;
    int long_pulse = 0;
    logic [7:0] wa [0:15];
    logic [7:0] wd [0:15];
    logic we_d = 1'b0;

    // Record every write strobe and flag any strobe longer than one cycle
    always @(negedge clk) begin
        if (rst_n && reg_we) begin
            if (wcount < 16) begin
                wa[wcount] = reg_addr;
                wd[wcount] = reg_wdata;
            end
            wcount++;
        end
        if (reg_we && we_d) long_pulse++;
        we_d = reg_we;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b0; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b1; qwait();
        qwait();
    endtask

    // Send one byte MSB first; ack is 1 only if SDA is held low for the whole ninth high phase
    task automatic send_byte(input logic [7:0] b, output bit ack);
        bit a1, a2;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; qwait();
            scl_m = 1'b1; qwait(); qwait();
            scl_m = 1'b0; qwait();
        end
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        a1 = sda_oe && !sda_bus;
        qwait();
        a2 = sda_oe && !sda_bus;
        scl_m = 1'b0; qwait();
        ack = a1 && a2;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        check(sda_oe == 1'b0, "R10 sda_oe in reset", sda_oe, 0);
        check(reg_we == 1'b0, "R10 reg_we in reset", reg_we, 0);
        check(reg_addr == 8'h00 && reg_wdata == 8'h00, "R10 outputs zero in reset",
              {reg_addr, reg_wdata}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_burst();
        bit ack;
        strap = 2'b00; wcount = 0;
        bus_start();
        send_byte(8'hC0, ack); check(ack, "R1 R5 ack of address 0xC0", ack, 1);
        send_byte(8'h10, ack); check(ack, "R5 ack of pointer byte", ack, 1);
        check(wcount == 0, "R6 pointer byte writes nothing", wcount, 0);
        send_byte(8'hA5, ack); check(ack, "R5 ack of data byte", ack, 1);
        send_byte(8'h3C, ack); check(ack, "R5 ack of second data byte", ack, 1);
        bus_stop();
        check(wcount == 2, "R7 one strobe per data byte", wcount, 2);
        check(wa[0] == 8'h10 && wd[0] == 8'hA5, "R4 R7 first write", {wa[0], wd[0]}, 16'h10A5);
        check(wa[1] == 8'h11 && wd[1] == 8'h3C, "R7 pointer advanced", {wa[1], wd[1]}, 16'h113C);
    endtask

    task automatic t_strap();
        bit ack;
        strap = 2'b10; wcount = 0;
        bus_start();
        send_byte(8'hC0, ack); check(!ack, "R1 strap 10 rejects 0xC0", ack, 0);
        bus_stop();
        bus_start();
        send_byte(8'hC4, ack); check(ack, "R1 strap 10 accepts 0xC4", ack, 1);
        send_byte(8'h05, ack);
        send_byte(8'h81, ack);
        bus_stop();
        check(wcount == 1 && wa[0] == 8'h05 && wd[0] == 8'h81, "R1 write under strap 10",
              {wa[0], wd[0]}, 16'h0581);
        strap = 2'b00;
    endtask

    task automatic t_read();
        bit ack;
        wcount = 0;
        bus_start();
        send_byte(8'hC1, ack); check(!ack, "R2 read request not acked", ack, 0);
        send_byte(8'h00, ack); check(!ack, "R9 byte after read request ignored", ack, 0);
        send_byte(8'h77, ack); check(!ack, "R9 later byte ignored", ack, 0);
        bus_stop();
        check(wcount == 0, "R9 no write after read request", wcount, 0);
    endtask

    task automatic t_mismatch();
        bit ack;
        wcount = 0;
        bus_start();
        send_byte(8'hC6, ack); check(!ack, "R1 wrong address not acked", ack, 0);
        send_byte(8'h30, ack); check(!ack, "R9 ignored after mismatch", ack, 0);
        send_byte(8'h99, ack);
        check(wcount == 0, "R9 no write after mismatch", wcount, 0);
        bus_start();
        send_byte(8'hC0, ack); check(ack, "R3 repeated START resumes address", ack, 1);
        send_byte(8'h30, ack);
        send_byte(8'h99, ack);
        bus_stop();
        check(wcount == 1 && wa[0] == 8'h30 && wd[0] == 8'h99, "R3 write after restart",
              {wa[0], wd[0]}, 16'h3099);
    endtask

    task automatic t_wrap();
        bit ack;
        wcount = 0;
        bus_start();
        send_byte(8'hC0, ack);
        send_byte(8'hFF, ack);
        send_byte(8'h11, ack);
        send_byte(8'h22, ack);
        bus_stop();
        check(wa[0] == 8'hFF && wd[0] == 8'h11, "R8 write at 0xFF", {wa[0], wd[0]}, 16'hFF11);
        check(wa[1] == 8'h00 && wd[1] == 8'h22, "R8 wrap to 0x00", {wa[1], wd[1]}, 16'h0022);
    endtask

    task automatic t_restart();
        bit ack;
        wcount = 0;
        bus_start();
        send_byte(8'hC0, ack);
        send_byte(8'h20, ack);
        send_byte(8'h55, ack);
        bus_start();
        send_byte(8'hC0, ack); check(ack, "R3 address after repeated START", ack, 1);
        send_byte(8'h40, ack);
        check(wcount == 1, "R3 R6 new pointer byte not written", wcount, 1);
        send_byte(8'h66, ack);
        bus_stop();
        check(wcount == 2 && wa[1] == 8'h40 && wd[1] == 8'h66, "R3 pointer reloaded",
              {wa[1], wd[1]}, 16'h4066);
        check(sda_oe == 1'b0, "R3 SDA released after STOP", sda_oe, 0);
    endtask

    initial begin
        t_reset();
        t_burst();
        t_strap();
        t_read();
        t_mismatch();
        t_wrap();
        t_restart();
        check(long_pulse == 0, "R7 strobe one cycle long", long_pulse, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule